// File: doc/BRIEF.md
# Host Link Activity Monitor

This block decides whether an upstream host link is still alive. It watches two things: a host supply-sense input, and a start-of-frame strobe that carries an 11-bit frame number. A decoder outside the block supplies the strobe and the number. On a healthy link a start-of-frame arrives once per millisecond.

A saturating timer counts microsecond ticks. A `tick_us` input supplies the time base. The timer restarts on every start-of-frame strobe. Two thresholds are compared against the timer:

- A short one (`LOST_US`, 2048 µs by default) gives a "host lost" flag.
- A long one (`TIMEOUT_US`, 1 s by default) gives a "host timeout" flag.

A 2-bit level input selects which of these counts as a break. Losing the supply sense also forces a break. A break produces a one-cycle interrupt request when it rises. The block also latches the most recent frame number for software to read.

Top module: `host_link_monitor`

## Requirements
- R1: The timer returns to 0 on the clock edge that samples `sof_valid` high while supply is present. It increments by one on each edge that samples `tick_us` high, and it stops at `TIMEOUT_US` instead of wrapping.
- R2: `host_lost` is high exactly when the timer value is at least `LOST_US`.
- R3: `host_timeout` is high exactly when the timer value is at least `TIMEOUT_US`.
- R4: `break_active` is a register. It is updated every cycle from the selected condition: `host_lost` when `brk_level` is 2'b00, and `host_timeout` for any other value. It therefore lags its source by one cycle.
- R5: `vbus_sense` passes through a two-flop synchronizer. While the synchronized value is low:
  - `break_active` is forced high;
  - the timer is held at `TIMEOUT_US`;
  - `sof_valid` does not clear the timer.
  A falling `vbus_sense` therefore raises `break_active` on the third clock edge.
- R6: `break_irq` is high for exactly one cycle, in the cycle in which `break_active` goes from low to high. It stays low while `break_active` stays high.
- R7: `frame_idx` loads `sof_frame` on every edge that samples `sof_valid` high, whatever the supply state, and holds otherwise.
- R8: During and after reset, until the inputs change:
  - the synchronized supply reads absent;
  - the timer holds `TIMEOUT_US`;
  - `host_lost`, `host_timeout` and `break_active` are high;
  - `break_irq` is low;
  - `frame_idx` is 0.
- R9: When `tick_us` is low and no start-of-frame is sampled, the timer holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| tick_us | input | 1 | One-cycle strobe marking each microsecond |
| vbus_sense | input | 1 | Host supply present (asynchronous) |
| sof_valid | input | 1 | Start-of-frame strobe from the packet decoder |
| sof_frame | input | 11 | Frame number carried by the strobe |
| brk_level | input | 2 | Break threshold select: 0 selects the short threshold, other values the long one |
| frame_idx | output | 11 | Last frame number received |
| host_lost | output | 1 | No start-of-frame for at least `LOST_US` ticks |
| host_timeout | output | 1 | No start-of-frame for at least `TIMEOUT_US` ticks |
| break_active | output | 1 | Registered break condition |
| break_irq | output | 1 | One-cycle break interrupt request |

## Verification
The timer is the only hidden state. A wrong timer value shows up at the ports as `host_lost` or `host_timeout` switching on the wrong tick. The flags are pure decodes of the timer, so a miscount is visible in the same cycle as the bad value. A fault in the break register or in the edge logic shows at `break_active` or `break_irq` one cycle after the flag changes: a missing pulse, a repeated pulse, or the wrong threshold. A supply-path fault shows as an error in the three-edge latency from a falling `vbus_sense` to `break_active`.

// File: rtl/hlm_pkg.sv
package hlm_pkg;
  localparam int FRAME_W = 11;
  localparam int LEVEL_W = 2;
  localparam logic [LEVEL_W-1:0] LEVEL_SHORT = '0;

  function automatic int cnt_width(input int max_val);
    return (max_val < 2) ? 1 : $clog2(max_val + 1);
  endfunction
endpackage

// File: rtl/hlm_sync.sv
module hlm_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], d_async};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/hlm_timer.sv
module hlm_timer #(
  parameter int SAT_VAL = 1000000,
  parameter int CNT_W   = hlm_pkg::cnt_width(SAT_VAL)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             restart,
  input  logic             force_sat,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] SAT_C = CNT_W'(SAT_VAL);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (force_sat) begin
      cnt_d  = SAT_C;
      cnt_en = 1'b1;
    end else if (restart) begin
      cnt_d  = '0;
      cnt_en = 1'b1;
    end else if (tick && (cnt_q != SAT_C)) begin
      cnt_d  = cnt_q + 1'b1;
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= SAT_C;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

  assert_sat_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= SAT_C);
  assert_restart_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (restart && !force_sat) |=> (cnt_q == '0));
  assert_force_sat_R5: assert property (@(posedge clk) disable iff (!rst_n)
    force_sat |=> (cnt_q == SAT_C));
  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !restart && !force_sat) |=> $stable(cnt_q));
endmodule

// File: rtl/hlm_break.sv
module hlm_break #(
  parameter int LOST_VAL = 2048,
  parameter int SAT_VAL  = 1000000,
  parameter int CNT_W    = hlm_pkg::cnt_width(SAT_VAL)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [CNT_W-1:0]           cnt,
  input  logic                       supply_ok,
  input  logic [hlm_pkg::LEVEL_W-1:0] level,
  output logic                       lost,
  output logic                       timed_out,
  output logic                       brk,
  output logic                       irq
);
  localparam logic [CNT_W-1:0] LOST_C = CNT_W'(LOST_VAL);
  localparam logic [CNT_W-1:0] SAT_C  = CNT_W'(SAT_VAL);

  logic brk_q, brk_d;
  logic irq_q, irq_d;
  logic sel_cond;

  always_comb begin
    lost      = (cnt >= LOST_C);
    timed_out = (cnt >= SAT_C);
    sel_cond  = (level == hlm_pkg::LEVEL_SHORT) ? lost : timed_out;
    brk_d     = !supply_ok || sel_cond;
    irq_d     = brk_d && !brk_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      brk_q <= 1'b1;
      irq_q <= 1'b0;
    end else begin
      brk_q <= brk_d;
      irq_q <= irq_d;
    end
  end

  assign brk = brk_q;
  assign irq = irq_q;

  assert_irq_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |=> !irq_q);
  assert_irq_on_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> (brk_q && !$past(brk_q)));
  assert_flag_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
    timed_out |-> lost);
  assert_supply_break_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> brk_q);
endmodule

// File: rtl/host_link_monitor.sv
module host_link_monitor #(
  parameter int LOST_US    = 2048,
  parameter int TIMEOUT_US = 1000000,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_us,
  input  logic        vbus_sense,
  input  logic        sof_valid,
  input  logic [10:0] sof_frame,
  input  logic [1:0]  brk_level,
  output logic [10:0] frame_idx,
  output logic        host_lost,
  output logic        host_timeout,
  output logic        break_active,
  output logic        break_irq
);
  localparam int CNT_W = hlm_pkg::cnt_width(TIMEOUT_US);

  logic             supply_ok;
  logic [CNT_W-1:0] timer_val;
  logic [hlm_pkg::FRAME_W-1:0] frame_q, frame_d;

  hlm_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (vbus_sense),
    .q_sync  (supply_ok)
  );

  hlm_timer #(.SAT_VAL(TIMEOUT_US), .CNT_W(CNT_W)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick_us),
    .restart   (sof_valid),
    .force_sat (!supply_ok),
    .cnt       (timer_val)
  );

  hlm_break #(.LOST_VAL(LOST_US), .SAT_VAL(TIMEOUT_US), .CNT_W(CNT_W)) u_break (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnt       (timer_val),
    .supply_ok (supply_ok),
    .level     (brk_level),
    .lost      (host_lost),
    .timed_out (host_timeout),
    .brk       (break_active),
    .irq       (break_irq)
  );

  always_comb begin
    frame_d = sof_valid ? sof_frame : frame_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) frame_q <= '0;
    else        frame_q <= frame_d;
  end

  assign frame_idx = frame_q;

  initial begin
    assert_threshold_order_R3: assert (LOST_US < TIMEOUT_US);
  end

  assert_frame_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sof_valid |=> (frame_idx == $past(sof_frame)));
  assert_frame_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !sof_valid |=> $stable(frame_idx));
endmodule

// File: tb/test_host_link_monitor.sv
module test_host_link_monitor;
  localparam int LOST = 20;
  localparam int TO   = 100;
  localparam int NVEC = 10;
  // fields: level [29:28], frame [26:16], tick count [11:0]
  localparam logic [31:0] VEC [NVEC] = '{
    {2'b00, 2'b00, 1'b0, 11'h001, 4'h0, 12'd5},
    {2'b00, 2'b00, 1'b0, 11'h7FF, 4'h0, 12'd19},
    {2'b00, 2'b00, 1'b0, 11'h000, 4'h0, 12'd20},
    {2'b00, 2'b00, 1'b0, 11'h2AA, 4'h0, 12'd60},
    {2'b00, 2'b01, 1'b0, 11'h555, 4'h0, 12'd60},
    {2'b00, 2'b10, 1'b0, 11'h123, 4'h0, 12'd99},
    {2'b00, 2'b11, 1'b0, 11'h400, 4'h0, 12'd100},
    {2'b00, 2'b01, 1'b0, 11'h0F0, 4'h0, 12'd150},
    {2'b00, 2'b00, 1'b0, 11'h00F, 4'h0, 12'd150},
    {2'b00, 2'b10, 1'b0, 11'h3C3, 4'h0, 12'd0}
  };

  logic clk = 1'b0;
  logic rst_n, tick_us, vbus_sense, sof_valid;
  logic [10:0] sof_frame;
  logic [1:0]  brk_level;
  logic [10:0] frame_idx;
  logic host_lost, host_timeout, break_active, break_irq;

  int n_tests = 0;
  int n_fail  = 0;
  int irq_acc = 0;

  always #4 clk = ~clk;

  host_link_monitor #(.LOST_US(LOST), .TIMEOUT_US(TO)) i_host_link_monitor (
    .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .vbus_sense(vbus_sense),
    .sof_valid(sof_valid), .sof_frame(sof_frame), .brk_level(brk_level),
    .frame_idx(frame_idx), .host_lost(host_lost), .host_timeout(host_timeout),
    .break_active(break_active), .break_irq(break_irq)
  );

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      irq_acc += int'(break_irq);
    end
  endtask

  task automatic send_sof(input logic [10:0] f);
    sof_valid = 1'b1; sof_frame = f; tick_us = 1'b0;
    @(negedge clk);
    sof_valid = 1'b0;
    irq_acc = 0;
  endtask

  initial begin
    #1500000;
    n_fail++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; tick_us = 1'b0; vbus_sense = 1'b0; sof_valid = 1'b0;
    sof_frame = '0; brk_level = 2'b00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    run(2);
    // R8 reset state
    check("R8 lost", int'(host_lost), 1);
    check("R8 timeout", int'(host_timeout), 1);
    check("R8 break", int'(break_active), 1);
    check("R8 irq", int'(break_irq), 0);
    check("R8 frame", int'(frame_idx), 0);

    vbus_sense = 1'b1;
    run(3);

    // table walk: R1 R2 R3 R4 R6 R7
    for (int v = 0; v < NVEC; v++) begin
      int n;
      logic [1:0] lvl;
      bit e_lost, e_to, e_brk;
      n   = int'(VEC[v][11:0]);
      lvl = VEC[v][29:28];
      send_sof(VEC[v][26:16]);
      brk_level = lvl;
      tick_us = 1'b1;
      run(n);
      tick_us = 1'b0;
      run(2);
      e_lost = (((n > TO) ? TO : n) >= LOST);
      e_to   = (n >= TO);
      e_brk  = (lvl == 2'b00) ? e_lost : e_to;
      check("R2 lost", int'(host_lost), int'(e_lost));
      check("R3 timeout", int'(host_timeout), int'(e_to));
      check("R4 break", int'(break_active), int'(e_brk));
      check("R6 irq count", irq_acc, int'(e_brk));
      check("R7 frame", int'(frame_idx), int'(VEC[v][26:16]));
    end

    // R4 level switch with timer at 60
    send_sof(11'h011);
    brk_level = 2'b01; tick_us = 1'b1;
    run(60);
    tick_us = 1'b0;
    run(2);
    check("R4 long level no break", int'(break_active), 0);
    irq_acc = 0;
    brk_level = 2'b00;
    run(1);
    check("R4 switch latency", int'(break_active), 1);
    run(3);
    check("R6 single pulse on switch", irq_acc, 1);

    // R9 no tick holds timer
    send_sof(11'h022);
    run(50);
    check("R9 no tick no loss", int'(host_lost), 0);

    // R5 supply loss latency
    irq_acc = 0;
    vbus_sense = 1'b0;
    run(2);
    check("R5 break before sync", int'(break_active), 0);
    run(1);
    check("R5 break after 3 edges", int'(break_active), 1);
    check("R1 saturated on loss", int'(host_timeout), 1);
    run(3);
    check("R6 irq on supply loss", irq_acc, 1);
    send_sof(11'h155);
    run(2);
    check("R5 sof ignored when unpowered", int'(host_lost), 1);
    check("R7 frame latched unpowered", int'(frame_idx), 'h155);

    // R5 supply back: timer stays saturated until sof
    irq_acc = 0;
    vbus_sense = 1'b1;
    run(4);
    check("R5 held after restore", int'(break_active), 1);
    check("R6 no extra irq", irq_acc, 0);
    send_sof(11'h156);
    run(2);
    check("R1 cleared by sof", int'(host_lost), 0);
    check("R4 break cleared", int'(break_active), 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule